// File: doc/BRIEF.md
# Switched-Capacitor Waveform Corrector with Hit Decision

This block cleans up one channel's region-of-interest waveform after the readout ADC has digitized it, and then decides whether the channel carries a hit. Each trigger brings a start-cell index and a frame of 200 raw 12-bit samples. Sample k was stored in capacitor cell (start + k) mod 2048. The cells form two cascaded arrays of 1024 cells each.

The processing runs in four steps. First, a per-cell offset is read from a lookup RAM and subtracted from each sample, with saturation. The frame is then put back into time order, which swaps its two halves when the start cell lies in the second array. The spike that the previous readout leaves on the last cell it read is replaced by interpolation from the neighbouring cells. Last, the corrected samples that fall inside a programmable window are summed and compared with a threshold.

Samples enter on a valid/ready stream and corrected samples leave on a second one. An input transfer happens on a rising edge where `in_valid` and `in_ready` are both high. An output transfer happens where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values. The source may insert idle cycles at any point, and so may the sink. The whole frame is buffered before any of it is sent, so `in_ready` and `out_valid` are never high together. A single board-level instance serves one channel, so a 16-channel board uses 16 instances. The trigger, the configuration and the offset-table write port are plain control pins.

Top module: `wc_waveform_corr`

## Requirements
- R1: After reset, `in_ready`, `out_valid` and `hit_valid` are low and no repair history exists.
- R2: A `trig` pulse is accepted only when no frame is being captured or sent. Acceptance latches `trig_cell`, `cfg_win_start`, `cfg_win_len` and `cfg_threshold`. On the following cycle `in_ready` goes high, and it stays high until exactly 200 samples have been taken. A `trig` pulse, or a change of the configuration, while a frame is in progress has no effect on that frame.
- R3: Corrected sample k equals raw − table[(start + k) mod 2048], clamped to the range 0..4095. Each table entry is a signed 12-bit two's-complement value, written through `ofs_we`/`ofs_addr`/`ofs_data`.
- R4: The output order depends on the start cell. If it is 1024 or more, the frame is sent as samples k = 100..199 followed by k = 0..99. Otherwise it is sent as k = 0..199.
- R5: Let L = (previous start + 199) mod 2048. The samples at cells L and L+1 that lie in the current region are replaced. When both cells L−1 and L+2 lie in the region, the replacement is floor((v[L−1] + v[L+2]) / 2). Otherwise it is the value of whichever of the two lies in the region.
- R6: The first frame after reset has no spike repair.
- R7: The output stream carries 200 samples per frame. `out_last` is high on the 200th, and data and last are held while the sink stalls.
- R8: The sum covers output positions j with `cfg_win_start` ≤ j < `cfg_win_start` + `cfg_win_len`. Positions past 199 add nothing. `hit` is 1 only when sum > threshold (strict).
- R9: `hit_valid` rises on the cycle after the last output transfer, and `out_valid` is never high while `hit_valid` is high. `hit_valid` and `hit` hold until the next accepted trigger, which clears `hit_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig | input | 1 | Trigger pulse, starts a frame when idle |
| trig_cell | input | 11 | Capacitor cell of sample 0 |
| cfg_win_start | input | 8 | First output position of the sum window |
| cfg_win_len | input | 8 | Number of positions in the sum window |
| cfg_threshold | input | 20 | Hit threshold, compared strictly |
| ofs_we | input | 1 | Offset table write enable |
| ofs_addr | input | 11 | Offset table cell address |
| ofs_data | input | 12 | Signed offset value |
| in_valid | input | 1 | Raw sample valid |
| in_ready | output | 1 | Block accepts a raw sample |
| in_data | input | 12 | Raw sample |
| out_valid | output | 1 | Corrected sample valid |
| out_ready | input | 1 | Sink accepts a corrected sample |
| out_data | output | 12 | Corrected sample in time order |
| out_last | output | 1 | Marks the 200th sample of a frame |
| hit_valid | output | 1 | Hit decision available |
| hit | output | 1 | Window sum exceeded threshold |

## Verification
Wrong repair history shows up in the next frame, not the current one, as wrong values at one or two positions next to the previous region's last cell. For that reason the frames are chained so that each start cell lands the old last cell in the middle of the region, on either edge, or outside it. A wrong offset address or a wrong reorder decision corrupts samples from the first transfer of the frame on, while a faulty sample counter appears as a misplaced `out_last` or a late `hit_valid` within the same frame. A window or threshold fault appears only at `hit` one cycle after the last sample. Thresholds are therefore set exactly at and just below the expected sum.

// File: rtl/wc_pkg.sv
`timescale 1ns/1ps
package wc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CAP   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_OUT   = 2'd3
  } wc_state_e;
endpackage

// File: rtl/wc_offset_lut.sv
`timescale 1ns/1ps
// Cell-indexed offset RAM with one registered read, followed by a
// saturating subtract of the signed offset from the raw sample.
module wc_offset_lut #(
  parameter int SAMP_W = 12,
  parameter int CELL_W = 11,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CELL_W-1:0] wr_addr,
  input  logic [SAMP_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [CELL_W-1:0] rd_addr,
  input  logic [SAMP_W-1:0] rd_raw,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              res_valid,
  output logic [IDX_W-1:0]  res_idx,
  output logic [SAMP_W-1:0] res_data
);
  localparam int DEPTH = 1 << CELL_W;
  localparam int DW    = SAMP_W + 2;
  localparam logic signed [DW-1:0] MAXV = DW'((1 << SAMP_W) - 1);

  logic [SAMP_W-1:0] mem [DEPTH];
  logic [SAMP_W-1:0] ofs_q;
  logic [SAMP_W-1:0] raw_q;
  logic [IDX_W-1:0]  idx_q;
  logic              v_q;
  logic signed [DW-1:0] diff;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) begin
      ofs_q <= mem[rd_addr];
      raw_q <= rd_raw;
      idx_q <= rd_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= rd_en;
  end

  always_comb begin
    diff = $signed({2'b00, raw_q}) - $signed({{2{ofs_q[SAMP_W-1]}}, ofs_q});
    if (diff < 0)          res_data = '0;
    else if (diff > MAXV)  res_data = '1;
    else                   res_data = diff[SAMP_W-1:0];
  end

  assign res_valid = v_q;
  assign res_idx   = idx_q;
endmodule

// File: rtl/wc_frame_buf.sv
`timescale 1ns/1ps
// Frame store: one write port, NRD combinational read ports.
module wc_frame_buf #(
  parameter int SAMP_W = 12,
  parameter int NSAMP  = 200,
  parameter int IDX_W  = 8,
  parameter int NRD    = 3
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [SAMP_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx  [NRD],
  output logic [SAMP_W-1:0] rd_data [NRD]
);
  logic [SAMP_W-1:0] store [NSAMP];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_idx] <= wr_data;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data[p] = store[rd_idx[p]];
  end
endmodule

// File: rtl/wc_hit_detect.sv
`timescale 1ns/1ps
// Window accumulator over output positions and strict threshold compare.
module wc_hit_detect #(
  parameter int SAMP_W = 12,
  parameter int IDX_W  = 8,
  parameter int SUM_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic [IDX_W-1:0]  win_start,
  input  logic [IDX_W-1:0]  win_len,
  input  logic [SUM_W-1:0]  thr,
  input  logic              s_valid,
  input  logic [IDX_W-1:0]  s_pos,
  input  logic [SAMP_W-1:0] s_data,
  input  logic              s_last,
  output logic              hit_valid,
  output logic              hit
);
  logic [SUM_W-1:0] acc;
  logic [SUM_W-1:0] acc_nxt;
  logic [IDX_W:0]   win_end;
  logic             in_win;

  assign win_end = {1'b0, win_start} + {1'b0, win_len};
  assign in_win  = (s_pos >= win_start) && ({1'b0, s_pos} < win_end);
  assign acc_nxt = in_win ? acc + SUM_W'(s_data) : acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      hit_valid <= 1'b0;
      hit       <= 1'b0;
    end else if (clear) begin
      acc       <= '0;
      hit_valid <= 1'b0;
      hit       <= 1'b0;
    end else if (s_valid) begin
      acc <= acc_nxt;
      if (s_last) begin
        hit_valid <= 1'b1;
        hit       <= (acc_nxt > thr);
      end
    end
  end
endmodule

// File: rtl/wc_waveform_corr.sv
`timescale 1ns/1ps
// Top: frame sequencing, reorder map and spike repair selection.
module wc_waveform_corr #(
  parameter int SAMP_W      = 12,
  parameter int ARRAY_CELLS = 1024,
  parameter int NUM_ARRAYS  = 2,
  parameter int NSAMP       = 200,
  localparam int TOTAL_CELLS = ARRAY_CELLS * NUM_ARRAYS,
  localparam int CELL_W      = $clog2(TOTAL_CELLS),
  localparam int IDX_W       = $clog2(NSAMP),
  localparam int SUM_W       = SAMP_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic [CELL_W-1:0] trig_cell,
  input  logic [IDX_W-1:0]  cfg_win_start,
  input  logic [IDX_W-1:0]  cfg_win_len,
  input  logic [SUM_W-1:0]  cfg_threshold,
  input  logic              ofs_we,
  input  logic [CELL_W-1:0] ofs_addr,
  input  logic [SAMP_W-1:0] ofs_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SAMP_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SAMP_W-1:0] out_data,
  output logic              out_last,
  output logic              hit_valid,
  output logic              hit
);
  import wc_pkg::*;

  localparam int HALF = NSAMP / 2;
  localparam logic [CELL_W-1:0] NSAMP_C = CELL_W'(NSAMP);
  localparam logic [IDX_W-1:0]  LAST_I  = IDX_W'(NSAMP - 1);
  localparam logic [IDX_W-1:0]  HALF_I  = IDX_W'(HALF);

  wc_state_e         state;
  logic [IDX_W-1:0]  cnt;
  logic [CELL_W-1:0] start_q;
  logic              swap_q;
  logic [IDX_W-1:0]  ws_q, wl_q;
  logic [SUM_W-1:0]  thr_q;
  logic [CELL_W-1:0] last_prev;
  logic              last_ok;
  logic              rep0_q, rep1_q, use_l_q, use_r_q;
  logic [IDX_W-1:0]  k0_q, k1_q, kl_q, kr_q;

  logic              trig_acc, cap_hs, out_hs;
  logic [CELL_W-1:0] d0, d1, dl, dr;

  assign trig_acc = (state == ST_IDLE) && trig;
  assign cap_hs   = (state == ST_CAP) && in_valid;
  assign out_hs   = (state == ST_OUT) && out_ready;

  // Position of the previous region's last cell and its neighbours,
  // measured from the new start cell (modulo the full cell count).
  assign d0 = last_prev - trig_cell;
  assign d1 = d0 + CELL_W'(1);
  assign dl = d0 - CELL_W'(1);
  assign dr = d0 + CELL_W'(2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      start_q   <= '0;
      swap_q    <= 1'b0;
      ws_q      <= '0;
      wl_q      <= '0;
      thr_q     <= '0;
      last_prev <= '0;
      last_ok   <= 1'b0;
      rep0_q    <= 1'b0;
      rep1_q    <= 1'b0;
      use_l_q   <= 1'b0;
      use_r_q   <= 1'b0;
      k0_q      <= '0;
      k1_q      <= '0;
      kl_q      <= '0;
      kr_q      <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (trig) begin
            state     <= ST_CAP;
            cnt       <= '0;
            start_q   <= trig_cell;
            swap_q    <= (trig_cell >= CELL_W'(ARRAY_CELLS));
            ws_q      <= cfg_win_start;
            wl_q      <= cfg_win_len;
            thr_q     <= cfg_threshold;
            rep0_q    <= last_ok && (d0 < NSAMP_C);
            rep1_q    <= last_ok && (d1 < NSAMP_C);
            use_l_q   <= (dl < NSAMP_C);
            use_r_q   <= (dr < NSAMP_C);
            k0_q      <= d0[IDX_W-1:0];
            k1_q      <= d1[IDX_W-1:0];
            kl_q      <= dl[IDX_W-1:0];
            kr_q      <= dr[IDX_W-1:0];
            last_prev <= trig_cell + CELL_W'(NSAMP - 1);
            last_ok   <= 1'b1;
          end
        end
        ST_CAP: begin
          if (in_valid) begin
            cnt <= cnt + IDX_W'(1);
            if (cnt == LAST_I) state <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          state <= ST_OUT;
          cnt   <= '0;
        end
        ST_OUT: begin
          if (out_ready) begin
            if (cnt == LAST_I) begin
              state <= ST_IDLE;
              cnt   <= '0;
            end else begin
              cnt <= cnt + IDX_W'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Offset subtraction stage
  logic              lut_v;
  logic [IDX_W-1:0]  lut_idx;
  logic [SAMP_W-1:0] lut_data;

  wc_offset_lut #(.SAMP_W(SAMP_W), .CELL_W(CELL_W), .IDX_W(IDX_W)) u_lut (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ofs_we),
    .wr_addr  (ofs_addr),
    .wr_data  (ofs_data),
    .rd_en    (cap_hs),
    .rd_addr  (start_q + CELL_W'(cnt)),
    .rd_raw   (in_data),
    .rd_idx   (cnt),
    .res_valid(lut_v),
    .res_idx  (lut_idx),
    .res_data (lut_data)
  );

  // Reorder: output position -> sample index
  logic [IDX_W-1:0]  k_sel;
  logic [IDX_W-1:0]  rd_idx  [3];
  logic [SAMP_W-1:0] rd_data [3];

  always_comb begin
    if (swap_q) k_sel = (cnt < HALF_I) ? cnt + HALF_I : cnt - HALF_I;
    else        k_sel = cnt;
  end

  assign rd_idx[0] = k_sel;
  assign rd_idx[1] = kl_q;
  assign rd_idx[2] = kr_q;

  wc_frame_buf #(.SAMP_W(SAMP_W), .NSAMP(NSAMP), .IDX_W(IDX_W), .NRD(3)) u_buf (
    .clk    (clk),
    .wr_en  (lut_v),
    .wr_idx (lut_idx),
    .wr_data(lut_data),
    .rd_idx (rd_idx),
    .rd_data(rd_data)
  );

  // Spike repair value
  logic [SAMP_W:0]   pair_sum;
  logic [SAMP_W-1:0] patch;
  logic              patch_here;

  assign pair_sum = {1'b0, rd_data[1]} + {1'b0, rd_data[2]};

  always_comb begin
    if (use_l_q && use_r_q) patch = pair_sum[SAMP_W:1];
    else if (use_l_q)       patch = rd_data[1];
    else                    patch = rd_data[2];
  end

  assign patch_here = (rep0_q && (k_sel == k0_q)) || (rep1_q && (k_sel == k1_q));

  assign in_ready  = (state == ST_CAP);
  assign out_valid = (state == ST_OUT);
  assign out_data  = patch_here ? patch : rd_data[0];
  assign out_last  = (state == ST_OUT) && (cnt == LAST_I);

  wc_hit_detect #(.SAMP_W(SAMP_W), .IDX_W(IDX_W), .SUM_W(SUM_W)) u_hit (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (trig_acc),
    .win_start(ws_q),
    .win_len  (wl_q),
    .thr      (thr_q),
    .s_valid  (out_hs),
    .s_pos    (cnt),
    .s_data   (out_data),
    .s_last   (out_last),
    .hit_valid(hit_valid),
    .hit      (hit)
  );
endmodule

// File: rtl/wc_waveform_corr_chk.sv
`timescale 1ns/1ps
module wc_waveform_corr_chk #(
  parameter int SAMP_W = 12,
  parameter int NSAMP  = 200
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trig,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [SAMP_W-1:0] out_data,
  input logic              out_last,
  input logic              hit_valid,
  input logic              hit
);
  localparam int CW = $clog2(NSAMP + 1);
  logic [CW-1:0] in_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_cnt <= '0;
    else if (out_valid && out_ready && out_last) in_cnt <= '0;
    else if (in_valid && in_ready) in_cnt <= in_cnt + CW'(1);
  end

  // R2: exactly NSAMP samples were taken before the frame ends
  p_frame_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |-> (in_cnt == CW'(NSAMP)));

  // R2: capture and output never overlap
  p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);

  // R7: stalled output holds
  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R9: decision follows the last transfer
  p_hit_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> hit_valid);

  // R9: decision holds until a trigger
  p_hit_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && !trig) |=> (hit_valid && $stable(hit)));

  // R9: no decision shown while a frame streams out
  p_quiet_stream_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !hit_valid);
endmodule

bind wc_waveform_corr wc_waveform_corr_chk #(.SAMP_W(SAMP_W), .NSAMP(NSAMP)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .trig     (trig),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .out_last (out_last),
  .hit_valid(hit_valid),
  .hit      (hit)
);

// File: tb/wc_waveform_corr_bench.sv
`timescale 1ns/1ps
module wc_waveform_corr_bench;
  localparam int NS = 200;
  localparam int NC = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig = 1'b0;
  logic [10:0] trig_cell = '0;
  logic [7:0]  cfg_win_start = '0;
  logic [7:0]  cfg_win_len = '0;
  logic [19:0] cfg_threshold = '0;
  logic        ofs_we = 1'b0;
  logic [10:0] ofs_addr = '0;
  logic [11:0] ofs_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [11:0] out_data;
  logic        out_last;
  logic        hit_valid;
  logic        hit;

  always #2.5 clk = ~clk;

  wc_waveform_corr u_wc_waveform_corr (
    .clk(clk), .rst_n(rst_n), .trig(trig), .trig_cell(trig_cell),
    .cfg_win_start(cfg_win_start), .cfg_win_len(cfg_win_len),
    .cfg_threshold(cfg_threshold), .ofs_we(ofs_we), .ofs_addr(ofs_addr),
    .ofs_data(ofs_data), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .hit_valid(hit_valid), .hit(hit)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int last_cyc = 0;
  int rdy_mode = 0;
  int prev_last = 0;
  bit prev_ok = 0;
  bit done = 0;

  logic [12:0] exp_q[$];
  string       tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ofs_f(input int c);
    if (c == 1510) return -2048;
    if (c == 1520) return 2047;
    return (c * 29) % 401 - 200;
  endfunction

  function automatic int raw_f(input int seed, input int k);
    if (k == 10) return 4000;
    if (k == 20) return 100;
    return (seed * 131 + k * 53 + (k * k) % 97) % 3800 + 100;
  endfunction

  // Monitor: pops the scoreboard on every output transfer (R7)
  initial begin
    forever begin
      @(negedge clk);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected sample", int'(out_data), -1);
        end else begin
          logic [12:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_data == e[11:0], t, int'(out_data), int'(e[11:0]));
          check(out_last == e[12], "R7 last flag", int'(out_last), int'(e[12]));
          if (out_last) last_cyc = cyc;
        end
      end
    end
  end

  // Sink back-pressure pattern (R7)
  initial begin
    int n = 0;
    forever begin
      @(posedge clk);
      #1;
      n++;
      out_ready = (rdy_mode == 0) ? 1'b1 : ((n % 3) != 0);
    end
  end

  task automatic load_offsets();
    for (int c = 0; c < NC; c++) begin
      @(posedge clk); #1;
      ofs_we = 1'b1; ofs_addr = 11'(c); ofs_data = 12'(ofs_f(c));
    end
    @(posedge clk); #1;
    ofs_we = 1'b0;
  endtask

  // thr_mode: 0 -> sum-1 (hit), 1 -> sum (no hit, strict), 2 -> sum+1
  task automatic run_frame(input int start, input int seed, input int ws, input int wl,
                           input int thr_mode, input int rmode, input bit busy_trig,
                           input string tag);
    int raw[NS];
    int corr[NS];
    int fixd[NS];
    bit patched[NS];
    int sum, thr, d, p0, p1, pl, pr, pv, k, gap;
    bit swap, exp_hit;
    for (int i = 0; i < NS; i++) begin
      int v;
      raw[i] = raw_f(seed, i);
      v = raw[i] - ofs_f((start + i) % NC);   // R3
      if (v < 0) v = 0;
      if (v > 4095) v = 4095;
      corr[i] = v;
      fixd[i] = v;
      patched[i] = 1'b0;
    end
    // R5 / R6 spike model
    if (prev_ok) begin
      d  = ((prev_last - start) % NC + NC) % NC;
      p0 = d; p1 = (d + 1) % NC; pl = (d + NC - 1) % NC; pr = (d + 2) % NC;
      if (pl < NS && pr < NS) pv = (corr[pl] + corr[pr]) / 2;
      else if (pl < NS)       pv = corr[pl];
      else                    pv = corr[pr];
      if (p0 < NS) begin fixd[p0] = pv; patched[p0] = 1'b1; end
      if (p1 < NS) begin fixd[p1] = pv; patched[p1] = 1'b1; end
    end
    swap = (start >= 1024);   // R4
    sum = 0;
    for (int j = 0; j < NS; j++) begin
      int kk;
      kk = swap ? ((j < 100) ? j + 100 : j - 100) : j;
      if (j >= ws && j < ws + wl) sum += fixd[kk];   // R8
      exp_q.push_back({(j == NS - 1), 12'(fixd[kk])});
      if (patched[kk])             tag_q.push_back({"R5 spike ", tag});
      else if (kk == 10 || kk == 20) tag_q.push_back({"R3 saturation ", tag});
      else                         tag_q.push_back({"R4 order ", tag});
    end
    thr = (thr_mode == 0) ? sum - 1 : (thr_mode == 1) ? sum : sum + 1;
    if (thr < 0) thr = 0;
    exp_hit = (sum > thr);
    prev_last = (start + NS - 1) % NC;
    prev_ok = 1'b1;
    rdy_mode = rmode;

    @(posedge clk); #1;
    trig = 1'b1; trig_cell = 11'(start);
    cfg_win_start = 8'(ws); cfg_win_len = 8'(wl); cfg_threshold = 20'(thr);
    @(posedge clk); #1;
    trig = 1'b0;
    @(negedge clk);
    check(hit_valid == 1'b0, "R9 cleared by trigger", int'(hit_valid), 0);
    check(in_ready == 1'b1, "R2 capture open after trigger", int'(in_ready), 1);

    k = 0; gap = 0;
    while (k < NS) begin
      @(posedge clk); #1;
      trig = busy_trig && (k == 50);
      if (busy_trig && k == 50) begin
        trig_cell = 11'(start + 333);
        cfg_threshold = '0;
        cfg_win_start = '0;
      end
      if (gap % 7 == 3) in_valid = 1'b0;
      else begin in_valid = 1'b1; in_data = 12'(raw[k]); end
      gap++;
      @(negedge clk);
      if (in_valid && in_ready) k++;
    end
    @(posedge clk); #1;
    in_valid = 1'b0; trig = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b0, "R2 capture closed after 200", int'(in_ready), 0);

    while (!hit_valid) @(negedge clk);
    check(exp_q.size() == 0, {"R7 frame complete ", tag}, exp_q.size(), 0);
    check(cyc == last_cyc + 1, "R9 decision timing", cyc - last_cyc, 1);
    check(hit == exp_hit, {"R8 hit ", tag}, int'(hit), int'(exp_hit));
    repeat (5) @(negedge clk);
    check(hit_valid == 1'b1, "R9 decision held", int'(hit_valid), 1);
    check(hit == exp_hit, "R9 hit held", int'(hit), int'(exp_hit));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(in_ready == 1'b0, "R1 in_ready", int'(in_ready), 0);
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(hit_valid == 1'b0, "R1 hit_valid", int'(hit_valid), 0);
    load_offsets();
    // R6: first frame, previous-last would fall inside if history were kept
    run_frame(2040, 1, 20, 40, 0, 1, 1'b0, "R6 first frame");
    // R5: both neighbours inside
    run_frame(100, 2, 0, 200, 1, 1, 1'b0, "R5 mid");
    // R3 saturation cells, R4 swapped halves, window past end
    run_frame(1500, 3, 180, 50, 0, 0, 1'b0, "R3 R4 swap");
    // R5: old last cell just before region, only right neighbour
    run_frame(1700, 4, 5, 1, 1, 1, 1'b0, "R5 left edge");
    // R5: old last cell is sample 199, only left neighbour
    run_frame(1700, 5, 100, 100, 2, 0, 1'b0, "R5 right edge");
    // R5 two cells at the end; R2 trigger and config change while busy
    run_frame(1701, 6, 30, 60, 1, 1, 1'b1, "R2 busy trigger");
    // R8 empty window never hits
    run_frame(500, 7, 10, 0, 1, 0, 1'b0, "R8 empty window");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule